// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether an I/O port access of one, two or four bytes may proceed. When `start` is raised it checks a task-segment descriptor, given as a present flag, a 4-bit type, a base and a limit. A bad descriptor faults at once. A good one starts two indirect lookups over a byte-wide synchronous memory port. The first lookup fetches a 16-bit pointer to the permission bitmap from a fixed place in the segment. The second fetches the 16-bit bitmap word that covers the requested port. One result pulse is then raised: a grant, or a general-protection fault whose error code is zero.

The work is done by one state machine. Its states are `ST_IDLE`, `ST_PTR_LO`, `ST_PTR_HI`, `ST_PTR_CHK`, `ST_MAP_LO`, `ST_MAP_HI`, `ST_MAP_CHK`, `ST_RSP_OK` and `ST_RSP_FLT`.

- `ST_IDLE` goes to `ST_PTR_LO` on a start with a good descriptor, or to `ST_RSP_FLT` on a start with a bad one.
- `ST_PTR_LO` goes to `ST_PTR_HI`, and `ST_PTR_HI` goes to `ST_PTR_CHK`.
- `ST_PTR_CHK` goes to `ST_RSP_FLT` when the bitmap bytes would pass the segment limit, and to `ST_MAP_LO` otherwise.
- `ST_MAP_LO` goes to `ST_MAP_HI`, and `ST_MAP_HI` goes to `ST_MAP_CHK`.
- `ST_MAP_CHK` goes to `ST_RSP_FLT` if any tested bit is set, and to `ST_RSP_OK` if none is.
- Both response states return to `ST_IDLE`.

The memory returns read data one cycle after a request. Each 16-bit field is read as two byte reads, low byte first.

Top module: `io_perm_checker`

## Requirements
- R1: While reset is held, and right after it is released, `busy`, `done`, `grant`, `fault` and `mem_req` are all 0.
- R2: A start taken in idle faults if the descriptor is not present, or its type is not 9, or its limit is below 103. The `done`+`fault` pulse comes one cycle after the start, and no memory request is made.
- R3: With a good descriptor, the bitmap pointer is read as two byte requests on the first two cycles after the start. The low byte is read at base+0x66 and the high byte at base+0x67, which makes the pointer little-endian. Read data arrives one cycle after its request.
- R4: The byte index is the pointer plus the port number shifted right by 3. If index+1 is greater than the latched limit, the block faults four cycles after the start and makes no bitmap read. Index+1 equal to the limit is allowed.
- R5: The bitmap word is read as two byte requests, the low byte at base+index and the high byte at base+index+1. It is used as low + 256*high.
- R6: The word is shifted right by port[2:0], and its low N bits are tested. `size_sel` encodes N: 0 means N=1, 1 means N=2, and 2 or 3 mean N=4. The access is granted only if all the tested bits are 0. The window may cross from the low byte into the high byte.
- R7: `done` is a single-cycle pulse, and exactly one of `grant` and `fault` is high with it. Neither is high at any other time. `err_code` is 0 on a fault. A full lookup reports seven cycles after the start.
- R8: A start raised while `busy` is high is ignored, together with any descriptor values it carries. The lookup in flight ends with its own result, and no extra result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (taken only when idle) |
| port_num | input | 16 | Port number to check |
| size_sel | input | 2 | Access size: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| desc_present | input | 1 | Descriptor present flag |
| desc_type | input | 4 | Descriptor type field |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 32 | Segment limit |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Check in progress |
| done | output | 1 | Result pulse |
| grant | output | 1 | Access allowed (with done) |
| fault | output | 1 | General-protection fault (with done) |
| err_code | output | 16 | Fault error code, always zero |

## Verification
A table of bitmap words is run against ports at bit offsets 0, 3, 5, 7 and 2. Each word pairs a set bit just inside or just outside the tested window with each access size. This separates a correct mask width from one that is off by one, and a correct shift from a missing one. Words with a bit set only in the high byte, with a 4-byte window that crosses the byte boundary, catch swapped or dropped high bytes. Directed runs set the limit to exactly index+1 and then one less, give each of the three bad-descriptor cases, and use the smallest legal limit. These runs also count memory requests to tell the fault-early paths apart. A final run raises start during a lookup to show it is ignored.

// File: rtl/iop_pkg.sv
package iop_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_PTR_CHK,
        ST_MAP_LO,
        ST_MAP_HI,
        ST_MAP_CHK,
        ST_RSP_OK,
        ST_RSP_FLT
    } iop_state_e;

    // number of permission bits tested for a size code
    function automatic int unsigned size_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/iop_desc_check.sv
module iop_desc_check #(
    parameter int LIM_W     = 32,
    parameter int TYPE_W    = 4,
    parameter int TSS_TYPE  = 9,
    parameter int MIN_LIMIT = 103
) (
    input  logic              present,
    input  logic [TYPE_W-1:0] seg_type,
    input  logic [LIM_W-1:0]  limit,
    output logic              usable
);
    always_comb begin
        usable = present
              && (seg_type == TYPE_W'(TSS_TYPE))
              && (limit >= LIM_W'(MIN_LIMIT));
    end
endmodule

// File: rtl/iop_limit_check.sv
module iop_limit_check #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] index,
    input  logic [ADDR_W-1:0] limit,
    output logic              beyond
);
    logic [ADDR_W:0] last_byte;

    always_comb begin
        // both bitmap bytes must lie inside the segment
        last_byte = {1'b0, index} + (ADDR_W+1)'(1);
        beyond    = last_byte > {1'b0, limit};
    end
endmodule

// File: rtl/iop_bit_window.sv
module iop_bit_window #(
    parameter int WORD_W = 16,
    parameter int MAX_N  = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        shift,
    input  logic [1:0]        size_code,
    output logic              deny
);
    import iop_pkg::*;

    logic [WORD_W-1:0] shifted;
    logic [MAX_N-1:0]  mask;

    always_comb begin
        shifted = word >> shift;
        for (int i = 0; i < MAX_N; i++) begin
            mask[i] = (i < int'(size_bits(size_code)));
        end
        deny = |(shifted[MAX_N-1:0] & mask);
    end
endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker #(
    parameter int ADDR_W    = 32,
    parameter int PORT_W    = 16,
    parameter int TYPE_W    = 4,
    parameter int TSS_TYPE  = 9,
    parameter int MIN_LIMIT = 103,
    parameter int PTR_OFS   = 'h66,
    parameter int ERR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PORT_W-1:0] port_num,
    input  logic [1:0]        size_sel,
    input  logic              desc_present,
    input  logic [TYPE_W-1:0] desc_type,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [ADDR_W-1:0] desc_limit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              grant,
    output logic              fault,
    output logic [ERR_W-1:0]  err_code
);
    import iop_pkg::*;

    localparam int WORD_W = 16;
    localparam int BIT_SH = 3;

    iop_state_e        state_q, state_d;
    logic [PORT_W-1:0] port_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] base_q, limit_q, idx_q, idx_calc;
    logic [7:0]        byte_q;
    logic [WORD_W-1:0] fetched;
    logic              desc_ok, idx_beyond, bit_deny;

    assign fetched  = {mem_rdata, byte_q};
    assign idx_calc = ADDR_W'(fetched) + ADDR_W'(port_q >> BIT_SH);

    iop_desc_check #(
        .LIM_W(ADDR_W), .TYPE_W(TYPE_W),
        .TSS_TYPE(TSS_TYPE), .MIN_LIMIT(MIN_LIMIT)
    ) u_desc (
        .present(desc_present), .seg_type(desc_type),
        .limit(desc_limit), .usable(desc_ok)
    );

    iop_limit_check #(.ADDR_W(ADDR_W)) u_lim (
        .index(idx_calc), .limit(limit_q), .beyond(idx_beyond)
    );

    iop_bit_window #(.WORD_W(WORD_W), .MAX_N(4)) u_bits (
        .word(fetched), .shift(port_q[2:0]),
        .size_code(size_q), .deny(bit_deny)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = desc_ok ? ST_PTR_LO : ST_RSP_FLT;
            ST_PTR_LO:  state_d = ST_PTR_HI;
            ST_PTR_HI:  state_d = ST_PTR_CHK;
            ST_PTR_CHK: state_d = idx_beyond ? ST_RSP_FLT : ST_MAP_LO;
            ST_MAP_LO:  state_d = ST_MAP_HI;
            ST_MAP_HI:  state_d = ST_MAP_CHK;
            ST_MAP_CHK: state_d = bit_deny ? ST_RSP_FLT : ST_RSP_OK;
            ST_RSP_OK:  state_d = ST_IDLE;
            ST_RSP_FLT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand and fetched-data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q  <= '0;
            size_q  <= '0;
            base_q  <= '0;
            limit_q <= '0;
            idx_q   <= '0;
            byte_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                port_q  <= port_num;
                size_q  <= size_sel;
                base_q  <= desc_base;
                limit_q <= desc_limit;
            end
            if (state_q == ST_PTR_HI || state_q == ST_MAP_HI) byte_q <= mem_rdata;
            if (state_q == ST_PTR_CHK) idx_q <= idx_calc;
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        busy     = (state_q != ST_IDLE);
        done     = 1'b0;
        grant    = 1'b0;
        fault    = 1'b0;
        err_code = '0;
        unique case (state_q)
            ST_PTR_LO: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(PTR_OFS);
            end
            ST_PTR_HI: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(PTR_OFS + 1);
            end
            ST_MAP_LO: begin
                mem_req  = 1'b1;
                mem_addr = base_q + idx_q;
            end
            ST_MAP_HI: begin
                mem_req  = 1'b1;
                mem_addr = base_q + idx_q + ADDR_W'(1);
            end
            ST_RSP_OK: begin
                done  = 1'b1;
                grant = 1'b1;
            end
            ST_RSP_FLT: begin
                done  = 1'b1;
                fault = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/iop_checker.sv
module iop_checker #(
    parameter int ADDR_W    = 32,
    parameter int TYPE_W    = 4,
    parameter int TSS_TYPE  = 9,
    parameter int MIN_LIMIT = 103,
    parameter int PTR_OFS   = 'h66
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              desc_present,
    input logic [TYPE_W-1:0] desc_type,
    input logic [ADDR_W-1:0] desc_base,
    input logic [ADDR_W-1:0] desc_limit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              grant,
    input logic              fault
);
    logic bad_desc;
    assign bad_desc = !desc_present || (desc_type != TYPE_W'(TSS_TYPE))
                   || (desc_limit < ADDR_W'(MIN_LIMIT));

    assert_bad_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bad_desc) |=> (done && fault && !mem_req));

    assert_ptr_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !bad_desc) |=>
            (mem_req && mem_addr == $past(desc_base) + ADDR_W'(PTR_OFS)));

    assert_pair_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (grant ^ fault));

    assert_quiet_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!grant && !fault));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind io_perm_checker iop_checker #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .TSS_TYPE(TSS_TYPE),
    .MIN_LIMIT(MIN_LIMIT), .PTR_OFS(PTR_OFS)
) u_iop_checker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .desc_present(desc_present), .desc_type(desc_type),
    .desc_base(desc_base), .desc_limit(desc_limit),
    .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
    .done(done), .grant(grant), .fault(fault)
);

// File: tb/io_perm_checker_bench.sv
module io_perm_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic [15:0] ofs;
        logic [15:0] port;
        logic [1:0]  sz;
        logic [15:0] word;
    } vec_t;

    // bitmap words chosen so each window edge and the byte boundary matter
    localparam vec_t VECS [NV] = '{
        '{32'h40,  32'h200, 16'h68, 16'h0010, 2'd0, 16'h0000},
        '{32'h40,  32'h200, 16'h68, 16'h0010, 2'd0, 16'h0001},
        '{32'h40,  32'h200, 16'h68, 16'h0013, 2'd1, 16'h0004},
        '{32'h40,  32'h200, 16'h68, 16'h0013, 2'd1, 16'h0010},
        '{32'h40,  32'h200, 16'h68, 16'h0017, 2'd2, 16'h0100},
        '{32'h40,  32'h200, 16'h68, 16'h0017, 2'd2, 16'hF87F},
        '{32'h40,  32'h200, 16'h68, 16'h000F, 2'd0, 16'h0080},
        '{32'h100, 32'h200, 16'h70, 16'h002A, 2'd2, 16'h0000},
        '{32'h100, 32'h200, 16'h70, 16'h0005, 2'd3, 16'h0100},
        '{32'h80,  32'h300, 16'h1F0, 16'h0017, 2'd2, 16'h0400}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] port_num = '0;
    logic [1:0]  size_sel = '0;
    logic        desc_present = 1'b1;
    logic [3:0]  desc_type = 4'd9;
    logic [31:0] desc_base = '0;
    logic [31:0] desc_limit = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy, done, grant, fault;
    logic [15:0] err_code;

    logic [7:0] mem [1024];
    int unsigned req_cnt = 0;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_perm_checker u_io_perm_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .port_num(port_num),
        .size_sel(size_sel), .desc_present(desc_present), .desc_type(desc_type),
        .desc_base(desc_base), .desc_limit(desc_limit), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .grant(grant), .fault(fault), .err_code(err_code)
    );

    // byte memory: data one cycle after the request
    always_ff @(posedge clk) begin
        if (mem_req) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_req) req_cnt <= req_cnt + 1;
    end

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_fault(input vec_t v);
        logic [31:0] idx;
        int n;
        logic [15:0] sh;
        idx = 32'(v.ofs) + 32'(v.port >> 3);
        if (idx + 1 > v.limit) return 1'b1;
        n  = (v.sz == 2'd0) ? 1 : (v.sz == 2'd1) ? 2 : 4;
        sh = v.word >> v.port[2:0];
        return (sh & 16'((1 << n) - 1)) != 0;
    endfunction

    task automatic load(input vec_t v);
        logic [31:0] idx;
        idx = 32'(v.ofs) + 32'(v.port >> 3);
        mem[10'(v.base + 32'h66)] = v.ofs[7:0];
        mem[10'(v.base + 32'h67)] = v.ofs[15:8];
        mem[10'(v.base + idx)]      = v.word[7:0];
        mem[10'(v.base + idx + 1)]  = v.word[15:8];
    endtask

    // issue one check; returns result, cycles to done and memory requests made
    task automatic run(input vec_t v, input logic pres, input logic [3:0] typ,
                       output logic got_fault, output int lat, output int reqs);
        int unsigned r0;
        @(negedge clk);
        r0 = req_cnt;
        port_num = v.port; size_sel = v.sz; desc_base = v.base;
        desc_limit = v.limit; desc_present = pres; desc_type = typ;
        start = 1'b1;
        lat = 0;
        got_fault = 1'b0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 20);
        got_fault = fault;
        check("R7", done && (grant ^ fault), {grant, fault}, 2'b01);
        if (fault) check("R7", err_code == 0, err_code, 0);
        @(negedge clk);
        reqs = int'(req_cnt - r0);
        check("R7", !done, done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic f;
        int lat, reqs;
        vec_t v;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", !busy && !done && !grant && !fault && !mem_req,
              {busy, done, grant, fault, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !busy && !done && !mem_req, {busy, done, mem_req}, 0);

        // table walk: R3 R5 R6
        for (int i = 0; i < NV; i++) begin
            load(VECS[i]);
            run(VECS[i], 1'b1, 4'd9, f, lat, reqs);
            check("R6", f == exp_fault(VECS[i]), f, exp_fault(VECS[i]));
            check("R7", lat == 7, lat, 7);
            check("R3", reqs == 4, reqs, 4);
        end

        // R4 limit boundary: index+1 == limit is allowed
        v = '{32'h40, 32'h69, 16'h68, 16'h0000, 2'd0, 16'h0000};
        load(v);
        run(v, 1'b1, 4'd9, f, lat, reqs);
        check("R4", !f && lat == 7, {f, 8'(lat)}, {1'b0, 8'd7});
        // R4 one less: fault after pointer read, no bitmap read
        v.limit = 32'h68;
        run(v, 1'b1, 4'd9, f, lat, reqs);
        check("R4", f && lat == 4, {f, 8'(lat)}, {1'b1, 8'd4});
        check("R4", reqs == 2, reqs, 2);

        // R2 bad descriptors: immediate fault, no memory traffic
        v = '{32'h40, 32'h200, 16'h68, 16'h0010, 2'd0, 16'h0000};
        load(v);
        run(v, 1'b0, 4'd9, f, lat, reqs);
        check("R2", f && lat == 1 && reqs == 0, {f, 8'(lat), 8'(reqs)}, {1'b1, 8'd1, 8'd0});
        run(v, 1'b1, 4'd11, f, lat, reqs);
        check("R2", f && lat == 1 && reqs == 0, {f, 8'(lat), 8'(reqs)}, {1'b1, 8'd1, 8'd0});
        v.limit = 32'd102;
        run(v, 1'b1, 4'd9, f, lat, reqs);
        check("R2", f && lat == 1 && reqs == 0, {f, 8'(lat), 8'(reqs)}, {1'b1, 8'd1, 8'd0});
        // R2 smallest legal limit passes the descriptor check
        v = '{32'h40, 32'd103, 16'h60, 16'h0000, 2'd0, 16'h0000};
        load(v);
        run(v, 1'b1, 4'd9, f, lat, reqs);
        check("R2", !f && lat == 7, {f, 8'(lat)}, {1'b0, 8'd7});

        // R8 start while busy is ignored
        v = '{32'h40, 32'h200, 16'h68, 16'h0010, 2'd0, 16'h0000};
        load(v);
        @(negedge clk);
        port_num = v.port; size_sel = v.sz; desc_base = v.base;
        desc_limit = v.limit; desc_present = 1'b1; desc_type = 4'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        desc_present = 1'b0; port_num = 16'h0000; mem[10'h6A + 10'h40] = 8'h00;
        start = 1'b1;
        lat = 2;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R8", done && grant && lat == 7, {done, grant, 8'(lat)}, {1'b1, 1'b1, 8'd7});
        @(negedge clk);
        check("R8", !done, done, 0);
        start = 1'b0; desc_present = 1'b1;
        repeat (8) begin
            @(negedge clk);
            check("R8", !done, done, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule